// File: doc/BRIEF.md
# Register-Mapped GPIO Port with Shared Reset Pin

This block is a small general-purpose I/O port on a simple processor bus. It has three bidirectional pins and a fourth pin that is only ever an input. Software reaches the port through three registers: the port data register, the output latch register and the direction register. Each bidirectional pin has an output enable and an output value for its pad, and a pad input that is synchronized before software sees it. An analog-select input for each pin comes from configuration outside the block.

A static configuration input sets the role of the fourth pin. When it is 0, the pin is a plain digital input and shows up in the port data register. When it is 1, the pin is an active-low reset request: its level drives a reset-request output, and its register bit reads as 0. The analog-select configuration outside the block comes up with every pin in analog mode. The block itself comes up with every pin as an input and the latch cleared, so no pad is driven until software asks for it.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset, every direction bit is 1, so all three `pin_oe` bits are 0. The latch is 0, so `pin_out` is 0. `bus_rdata` is 0 and `rst_req_n` is 1.
- R2: A direction bit of 1 turns its pin driver off (`pin_oe` bit 0). A direction bit of 0 turns it on (`pin_oe` bit 1). `pin_out` always shows the latch. The analog-select input has no effect on the driver.
- R3: A write to address 1 (latch) stores `bus_wdata[2:0]` in the latch. A read of address 1 returns the stored latch in bits [2:0], whatever the pin levels are.
- R4: A write to address 0 (port data) updates the latch exactly as a write to address 1 does.
- R5: Reading address 0 returns, in bit i (i = 0..2), the synchronized level of `pin_in[i]`. The bit reads as 0 while `ana_sel[i]` is 1.
- R6: Bit 3 of a port data read is the synchronized `aux_pin_in` when `rst_en_cfg` is 0, and reads as 0 when `rst_en_cfg` is 1.
- R7: When `rst_en_cfg` is 1, `rst_req_n` follows the synchronized `aux_pin_in`, and a low level is a reset request. When `rst_en_cfg` is 0, `rst_req_n` stays at 1.
- R8: Bits that have no function read as 0 and ignore writes. Address 3 reads as 0, and a write to it changes nothing.
- R9: `bus_rdata` is registered. It takes a new value only on a clock edge where `bus_rd_en` is 1, and holds otherwise. A read changes no register.
- R10: Each pad input passes through two flip-flops. A level that is present before clock edge k is visible at `rst_req_n` after edge k+1, and in a read captured at edge k+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_addr | input | 2 | Register select: 0 port data, 1 latch, 2 direction, 3 unused |
| bus_wr_en | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rd_en | input | 1 | Read strobe |
| bus_rdata | output | 8 | Registered read data |
| pin_in | input | 3 | Pad input levels of the bidirectional pins |
| pin_out | output | 3 | Output values for the bidirectional pins |
| pin_oe | output | 3 | Output driver enables, 1 = driving |
| ana_sel | input | 3 | Per-pin analog select from external configuration |
| aux_pin_in | input | 1 | Pad level of the input-only fourth pin |
| rst_en_cfg | input | 1 | Static role of the fourth pin: 1 = reset request, 0 = digital input |
| rst_req_n | output | 1 | Active-low reset request taken from the fourth pin |

## Verification
A write shows up at `pin_oe` and `pin_out` one edge after its strobe. A read shows up in `bus_rdata` one edge after its strobe. For a pad change, `rst_req_n` follows after two edges, and a read that captures it must be clocked on the third edge. The bench drives every stimulus at a falling edge and samples at a later falling edge. Before each port read it waits one extra cycle after changing the pads, so every sample lands exactly when its result is due. A separate probe samples `rst_req_n` after one edge and after two, which confirms the depth of the synchronizer.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  localparam int unsigned ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_PORT = 2'd0,
    REG_LAT  = 2'd1,
    REG_DIR  = 2'd2,
    REG_NONE = 2'd3
  } reg_sel_e;

endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= {stage_q[0], 1'b1};
    end
  end

  assign rst_sync_n = stage_q[1];

endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [W-1:0] meta_q;
  logic [W-1:0] stable_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q   <= RST_VAL;
      stable_q <= RST_VAL;
    end else begin
      meta_q   <= din;
      stable_q <= meta_q;
    end
  end

  assign dout = stable_q;

endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_port_pkg::*;
#(
  parameter int unsigned NPIO = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  reg_sel_e          sel,
  input  logic [NPIO-1:0]   wdata,
  output logic [NPIO-1:0]   dir_q,
  output logic [NPIO-1:0]   lat_q
);

  logic            dir_we;
  logic            lat_we;
  logic [NPIO-1:0] dir_d;
  logic [NPIO-1:0] lat_d;

  always_comb begin
    dir_we = 1'b0;
    lat_we = 1'b0;
    if (wr_en) begin
      unique case (sel)
        REG_PORT: lat_we = 1'b1;
        REG_LAT:  lat_we = 1'b1;
        REG_DIR:  dir_we = 1'b1;
        default:  begin end
      endcase
    end
  end

  always_comb begin
    dir_d = dir_q;
    lat_d = lat_q;
    if (dir_we) dir_d = wdata;
    if (lat_we) lat_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '1;
    end else if (dir_we) begin
      dir_q <= dir_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q <= '0;
    end else if (lat_we) begin
      lat_q <= lat_d;
    end
  end

  AST_NONE_ADDR_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel == REG_NONE) |=> ($stable(dir_q) && $stable(lat_q))); // R8

endmodule

// File: rtl/gpio_rdmux.sv
module gpio_rdmux
  import gpio_port_pkg::*;
#(
  parameter int unsigned NPIO = 3,
  parameter int unsigned DW   = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rd_en,
  input  reg_sel_e        sel,
  input  logic [NPIO-1:0] pin_sync,
  input  logic            aux_sync,
  input  logic [NPIO-1:0] ana_sel,
  input  logic            rst_en_cfg,
  input  logic [NPIO-1:0] dir_q,
  input  logic [NPIO-1:0] lat_q,
  output logic [DW-1:0]   rdata
);

  localparam int unsigned AUX_BIT = NPIO;

  logic [DW-1:0] port_view;
  logic [DW-1:0] lat_view;
  logic [DW-1:0] dir_view;
  logic [DW-1:0] rdata_d;

  always_comb begin
    port_view = '0;
    lat_view  = '0;
    dir_view  = '0;
    for (int i = 0; i < NPIO; i++) begin
      port_view[i] = pin_sync[i] & ~ana_sel[i];
      lat_view[i]  = lat_q[i];
      dir_view[i]  = dir_q[i];
    end
    port_view[AUX_BIT] = aux_sync & ~rst_en_cfg;
  end

  always_comb begin
    rdata_d = rdata;
    if (rd_en) begin
      unique case (sel)
        REG_PORT: rdata_d = port_view;
        REG_LAT:  rdata_d = lat_view;
        REG_DIR:  rdata_d = dir_view;
        default:  rdata_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
    end else if (rd_en) begin
      rdata <= rdata_d;
    end
  end

  AST_AUX_BIT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && sel == REG_PORT && rst_en_cfg) |=> (rdata[AUX_BIT] == 1'b0)); // R6

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata)); // R9

  generate
    if (DW > NPIO + 1) begin : g_upper
      AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rdata[DW-1:NPIO+1] == '0); // R8
    end
  endgenerate

endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_port_pkg::*;
#(
  parameter int unsigned NPIO = 3,
  parameter int unsigned DW   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr_en,
  input  logic [DW-1:0]     bus_wdata,
  input  logic              bus_rd_en,
  output logic [DW-1:0]     bus_rdata,
  input  logic [NPIO-1:0]   pin_in,
  output logic [NPIO-1:0]   pin_out,
  output logic [NPIO-1:0]   pin_oe,
  input  logic [NPIO-1:0]   ana_sel,
  input  logic              aux_pin_in,
  input  logic              rst_en_cfg,
  output logic              rst_req_n
);

  logic            rst_sync_n;
  logic [NPIO-1:0] pin_sync;
  logic            aux_sync;
  logic [NPIO-1:0] dir_q;
  logic [NPIO-1:0] lat_q;
  reg_sel_e        sel;
  logic            unused_wdata_hi;

  assign sel             = reg_sel_e'(bus_addr);
  assign unused_wdata_hi = ^bus_wdata[DW-1:NPIO];

  gpio_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  gpio_sync #(.W(NPIO), .RST_VAL('0)) u_pin_sync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .din   (pin_in),
    .dout  (pin_sync)
  );

  gpio_sync #(.W(1), .RST_VAL(1'b1)) u_aux_sync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .din   (aux_pin_in),
    .dout  (aux_sync)
  );

  gpio_regs #(.NPIO(NPIO)) u_regs (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .wr_en (bus_wr_en),
    .sel   (sel),
    .wdata (bus_wdata[NPIO-1:0]),
    .dir_q (dir_q),
    .lat_q (lat_q)
  );

  gpio_rdmux #(.NPIO(NPIO), .DW(DW)) u_rdmux (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .rd_en      (bus_rd_en),
    .sel        (sel),
    .pin_sync   (pin_sync),
    .aux_sync   (aux_sync),
    .ana_sel    (ana_sel),
    .rst_en_cfg (rst_en_cfg),
    .dir_q      (dir_q),
    .lat_q      (lat_q),
    .rdata      (bus_rdata)
  );

  assign pin_oe    = ~dir_q;
  assign pin_out   = lat_q;
  assign rst_req_n = rst_en_cfg ? aux_sync : 1'b1;

  AST_DIR_WRITE_OE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_wr_en && sel == REG_DIR) |=> (pin_oe == ~$past(bus_wdata[NPIO-1:0]))); // R2

  AST_LATCH_WRITE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_wr_en && sel == REG_LAT) |=> (pin_out == $past(bus_wdata[NPIO-1:0]))); // R3

  AST_PORT_WRITE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_wr_en && sel == REG_PORT) |=> (pin_out == $past(bus_wdata[NPIO-1:0]))); // R4

  AST_PINS_HOLD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !bus_wr_en |=> ($stable(pin_out) && $stable(pin_oe))); // R9

  AST_LAT_READBACK: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_rd_en && !bus_wr_en && sel == REG_LAT) |=> (bus_rdata[NPIO-1:0] == pin_out)); // R3

  AST_RSTREQ_IDLE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !rst_en_cfg |-> rst_req_n); // R7

endmodule

// File: tb/gpio_port_ctrl_test.sv
module gpio_port_ctrl_test;

  logic       clk;
  logic       rst_n;
  logic [1:0] bus_addr;
  logic       bus_wr_en;
  logic [7:0] bus_wdata;
  logic       bus_rd_en;
  logic [7:0] bus_rdata;
  logic [2:0] pin_in;
  logic [2:0] pin_out;
  logic [2:0] pin_oe;
  logic [2:0] ana_sel;
  logic       aux_pin_in;
  logic       rst_en_cfg;
  logic       rst_req_n;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  gpio_port_ctrl uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_wr_en  (bus_wr_en),
    .bus_wdata  (bus_wdata),
    .bus_rd_en  (bus_rd_en),
    .bus_rdata  (bus_rdata),
    .pin_in     (pin_in),
    .pin_out    (pin_out),
    .pin_oe     (pin_oe),
    .ana_sel    (ana_sel),
    .aux_pin_in (aux_pin_in),
    .rst_en_cfg (rst_en_cfg),
    .rst_req_n  (rst_req_n)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr  = a;
    bus_wdata = d;
    bus_wr_en = 1'b1;
    @(negedge clk);
    bus_wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr  = a;
    bus_rd_en = 1'b1;
    @(negedge clk);
    bus_rd_en = 1'b0;
    d = bus_rdata;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    logic [7:0] held;
    rst_n      = 1'b0;
    bus_addr   = 2'd0;
    bus_wr_en  = 1'b0;
    bus_wdata  = 8'h00;
    bus_rd_en  = 1'b0;
    pin_in     = 3'b000;
    ana_sel    = 3'b111;
    aux_pin_in = 1'b1;
    rst_en_cfg = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check("R1 oe", {5'd0, pin_oe}, 8'h00);
    check("R1 out", {5'd0, pin_out}, 8'h00);
    check("R1 rdata", bus_rdata, 8'h00);
    check("R1 rstreq", {7'd0, rst_req_n}, 8'h01);
    bus_rd(2'd2, rd);
    check("R1 dir", rd, 8'h07);
    bus_rd(2'd1, rd);
    check("R1 lat", rd, 8'h00);

    // R2 R3 R4 direction and latch sweep
    for (int d = 0; d < 8; d++) begin
      for (int l = 0; l < 8; l++) begin
        pin_in = ~l[2:0];
        bus_wr(2'd2, {5'd0, d[2:0]});
        bus_wr((l % 2 == 1) ? 2'd0 : 2'd1, {5'd0, l[2:0]});
        check("R2 oe", {5'd0, pin_oe}, {5'd0, ~d[2:0]});
        check((l % 2 == 1) ? "R4 out" : "R3 out", {5'd0, pin_out}, {5'd0, l[2:0]});
        bus_rd(2'd1, rd);
        check("R3 lat read", rd, {5'd0, l[2:0]});
        bus_rd(2'd2, rd);
        check("R2 dir read", rd, {5'd0, d[2:0]});
      end
    end

    // R5 R6 R7 port data sweep
    for (int rc = 0; rc < 2; rc++) begin
      for (int a = 0; a < 8; a++) begin
        for (int p = 0; p < 16; p++) begin
          @(negedge clk);
          rst_en_cfg = rc[0];
          ana_sel    = a[2:0];
          pin_in     = p[2:0];
          aux_pin_in = p[3];
          @(negedge clk);
          bus_rd(2'd0, rd);
          check(rc == 1 ? "R6 R5 port cfg1" : "R6 R5 port cfg0", rd,
                {4'd0, (rc == 1) ? 1'b0 : p[3], p[2:0] & ~a[2:0]});
          check("R7 rstreq", {7'd0, rst_req_n}, {7'd0, (rc == 1) ? p[3] : 1'b1});
        end
      end
    end

    // R2 analog select leaves the driver alone
    ana_sel = 3'b111;
    bus_wr(2'd2, 8'h02);
    check("R2 oe analog", {5'd0, pin_oe}, 8'h05);

    // R8 unused bits and unused address
    bus_wr(2'd1, 8'hFF);
    bus_rd(2'd1, rd);
    check("R8 lat upper", rd, 8'h07);
    bus_wr(2'd2, 8'hF8);
    bus_rd(2'd2, rd);
    check("R8 dir upper", rd, 8'h00);
    bus_wr(2'd3, 8'h07);
    bus_rd(2'd1, rd);
    check("R8 none lat", rd, 8'h07);
    bus_rd(2'd2, rd);
    check("R8 none dir", rd, 8'h00);
    bus_rd(2'd3, rd);
    check("R8 none read", rd, 8'h00);

    // R9 hold and no side effects
    ana_sel    = 3'b000;
    rst_en_cfg = 1'b0;
    pin_in     = 3'b101;
    aux_pin_in = 1'b0;
    repeat (3) @(negedge clk);
    bus_rd(2'd0, rd);
    check("R9 read", rd, 8'h05);
    held = bus_rdata;
    pin_in = 3'b010;
    repeat (4) @(negedge clk);
    check("R9 hold", bus_rdata, held);
    bus_rd(2'd0, rd);
    bus_rd(2'd0, rd);
    check("R9 repeat", rd, 8'h02);
    bus_rd(2'd1, rd);
    check("R9 no side effect lat", rd, 8'h07);
    check("R9 no side effect oe", {5'd0, pin_oe}, 8'h07);

    // R10 synchronizer depth
    rst_en_cfg = 1'b1;
    aux_pin_in = 1'b1;
    repeat (3) @(negedge clk);
    check("R10 pre", {7'd0, rst_req_n}, 8'h01);
    aux_pin_in = 1'b0;
    @(negedge clk);
    check("R10 one edge", {7'd0, rst_req_n}, 8'h01);
    @(negedge clk);
    check("R10 two edges", {7'd0, rst_req_n}, 8'h00);
    rst_en_cfg = 1'b0;
    pin_in     = 3'b000;
    repeat (3) @(negedge clk);
    pin_in = 3'b111;
    bus_rd(2'd0, rd);
    check("R10 read too early", rd, 8'h00);
    bus_rd(2'd0, rd);
    check("R10 read due", rd, 8'h07);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule